// File: doc/BRIEF.md
# Cache Port Bandwidth Tracker

This block models how long the two array-side ports of a cache stay occupied. One port serves lookups against the data array. The other writes returning lines into the array. Each port has an occupancy down-counter. Every accepted operation loads its counter with a number of busy cycles. The counter then drains by one per clock. A port is free only when its counter has drained to zero.

The surrounding cache logic presents a lookup together with its tag result, a flag saying whether a dirty victim is written back, and the requested byte count. The block grants the lookup only when the data port is free and the downstream output queue has room. A fill is granted only when the fill port is free. A refused fill stays at the head of its queue and is retried.

The block also keeps three saturating utilization counters: total cycles, data-port busy cycles and fill-port busy cycles. The reader computes the utilization ratios from these, and treats a ratio as zero when the total is zero.

Top module: `cache_port_budget`

## Requirements
- R1: An accepted lookup whose result is a hit (code 0) loads the data-port counter with ceil(bytes / W). W is the effective port width, 32 bytes by default. The data port then reads busy for exactly that many cycles.
- R2: An accepted lookup that is a miss (code 2) or a hit on a reserved line (code 1) loads LINE/W cycles (4 by default) when the writeback flag is set. It loads nothing when the flag is clear.
- R3: An accepted lookup with a reservation-failure result (code 3) costs no data-port cycles, whether or not the writeback flag is set.
- R4: An accepted fill loads the fill-port counter with LINE/W cycles. The fill port and the data port are charged independently and may be charged in the same cycle.
- R5: Each counter decrements by one per cycle and never goes below zero. A charge made in a given cycle adds to the decremented value. A port is reported free only when its counter is zero.
- R6: A lookup is accepted only when the data port is free and the output queue is not full. A valid lookup is flagged as a data-port stall exactly when the data port is busy.
- R7: A fill is accepted only when the fill port is free. A refused fill leaves the fill-port state unchanged.
- R8: A configured port width of 0 means the port width equals the line size. Under that setting a fill costs 1 cycle and a 200-byte hit on a 128-byte line costs 2 cycles.
- R9: Every cycle out of reset that is not a clear cycle, the total-cycle counter increments. Each busy counter increments when its port was busy in that cycle, sampled before the decrement.
- R10: The utilization counters saturate at all ones instead of wrapping. A synchronous clear zeroes all three, and the clear cycle itself is not counted.
- R11: After reset both ports read free, nothing is accepted unless requested, and all utilization counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_clear | input | 1 | Synchronous clear of the utilization counters |
| lookup_valid | input | 1 | A lookup is presented this cycle |
| lookup_result | input | 2 | Tag result: 0 hit, 1 hit on reserved line, 2 miss, 3 reservation failure |
| lookup_wb_sent | input | 1 | The lookup sends a dirty-line writeback |
| lookup_bytes | input | SIZE_W | Requested transfer size in bytes |
| outq_full | input | 1 | Downstream output queue is full |
| lookup_accept | output | 1 | Lookup granted this cycle |
| dport_stall | output | 1 | Valid lookup blocked by a busy data port |
| fill_valid | input | 1 | A returning line is at the head of the response queue |
| fill_accept | output | 1 | Fill granted this cycle |
| data_free | output | 1 | Data-port counter is zero |
| fill_free | output | 1 | Fill-port counter is zero |
| avail_cycles | output | STAT_W | Cycles counted since the last clear |
| data_busy_cycles | output | STAT_W | Cycles with the data port busy |
| fill_busy_cycles | output | STAT_W | Cycles with the fill port busy |

## Verification
A wrong occupancy count shows on the next clock edge as a free flag that comes back too early or too late. It then shows as a grant or stall decision that differs from the expected one. A wrong charge for one result code therefore shows within a few cycles of the lookup. A miscounted busy sample shows in the busy counters on the following edge. Because those counters accumulate, the error stays visible in every later comparison. Saturation and the width-equals-line setting are checked on a second instance with a narrow counter and a zero width setting.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    typedef enum logic [1:0] {
        RES_HIT      = 2'd0,
        RES_HIT_RSV  = 2'd1,
        RES_MISS     = 2'd2,
        RES_RSV_FAIL = 2'd3
    } lookup_result_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbw_charge_calc.sv
module pbw_charge_calc
    import pbw_pkg::*;
#(
    parameter int unsigned SIZE_W     = 8,
    parameter int unsigned EFF_W      = 32,
    parameter int unsigned LINE_BEATS = 4,
    parameter int unsigned CNT_W      = 4
) (
    input  logic [1:0]        result,
    input  logic              wb_sent,
    input  logic [SIZE_W-1:0] bytes,
    output logic [CNT_W-1:0]  cycles
);
    always_comb begin
        unique case (lookup_result_e'(result))
            RES_HIT:              cycles = CNT_W'(ceil_div(32'(bytes), EFF_W));
            RES_HIT_RSV, RES_MISS: cycles = wb_sent ? CNT_W'(LINE_BEATS) : '0;
            default:              cycles = '0;
        endcase
    end
endmodule

// File: rtl/pbw_occ_counter.sv
module pbw_occ_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] charge,
    output logic             free
);
    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] drained;

    assign drained = (occ != '0) ? occ - CNT_W'(1) : '0;
    assign free    = (occ == '0);

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= drained + charge;
    end
endmodule

// File: rtl/pbw_usage_counter.sv
module pbw_usage_counter #(
    parameter int unsigned STAT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [STAT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)             count <= '0;
        else if (inc && !(&count))  count <= count + STAT_W'(1);
    end
endmodule

// File: rtl/cache_port_budget.sv
module cache_port_budget
    import pbw_pkg::*;
#(
    parameter int unsigned LINE_BYTES     = 128,
    parameter int unsigned PORT_WIDTH_CFG = 32,
    parameter int unsigned SIZE_W         = 8,
    parameter int unsigned STAT_W         = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_clear,
    input  logic              lookup_valid,
    input  logic [1:0]        lookup_result,
    input  logic              lookup_wb_sent,
    input  logic [SIZE_W-1:0] lookup_bytes,
    input  logic              outq_full,
    output logic              lookup_accept,
    output logic              dport_stall,
    input  logic              fill_valid,
    output logic              fill_accept,
    output logic              data_free,
    output logic              fill_free,
    output logic [STAT_W-1:0] avail_cycles,
    output logic [STAT_W-1:0] data_busy_cycles,
    output logic [STAT_W-1:0] fill_busy_cycles
);
    localparam int unsigned EFF_W      = (PORT_WIDTH_CFG == 0) ? LINE_BYTES : PORT_WIDTH_CFG;
    localparam int unsigned LINE_BEATS = LINE_BYTES / EFF_W;
    localparam int unsigned MAX_HIT    = ceil_div((1 << SIZE_W) - 1, EFF_W);
    localparam int unsigned MAX_CHG    = max_u(MAX_HIT, LINE_BEATS);
    localparam int unsigned CNT_W      = $clog2(MAX_CHG + 1);

    generate
        if (LINE_BYTES % EFF_W != 0) begin : g_bad_width
            $error("line size must be a multiple of the port width");
        end
    endgenerate

    logic [CNT_W-1:0] lookup_cycles;
    logic [CNT_W-1:0] data_charge;
    logic [CNT_W-1:0] fill_charge;

    assign lookup_accept = lookup_valid && data_free && !outq_full;
    assign dport_stall   = lookup_valid && !data_free;
    assign fill_accept   = fill_valid && fill_free;
    assign data_charge   = lookup_accept ? lookup_cycles : '0;
    assign fill_charge   = fill_accept ? CNT_W'(LINE_BEATS) : '0;

    pbw_charge_calc #(
        .SIZE_W(SIZE_W), .EFF_W(EFF_W), .LINE_BEATS(LINE_BEATS), .CNT_W(CNT_W)
    ) u_calc (
        .result(lookup_result), .wb_sent(lookup_wb_sent),
        .bytes(lookup_bytes), .cycles(lookup_cycles)
    );

    pbw_occ_counter #(.CNT_W(CNT_W)) u_data_occ (
        .clk(clk), .rst(rst), .charge(data_charge), .free(data_free)
    );

    pbw_occ_counter #(.CNT_W(CNT_W)) u_fill_occ (
        .clk(clk), .rst(rst), .charge(fill_charge), .free(fill_free)
    );

    logic [2:0]              stat_inc;
    logic [2:0][STAT_W-1:0]  stat_val;

    assign stat_inc = {!fill_free, !data_free, 1'b1};

    generate
        for (genvar k = 0; k < 3; k++) begin : g_stat
            pbw_usage_counter #(.STAT_W(STAT_W)) u_cnt (
                .clk(clk), .rst(rst), .clr(stat_clear),
                .inc(stat_inc[k]), .count(stat_val[k])
            );
        end
    endgenerate

    assign avail_cycles     = stat_val[0];
    assign data_busy_cycles = stat_val[1];
    assign fill_busy_cycles = stat_val[2];
endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
    parameter int unsigned STAT_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              stat_clear,
    input logic              lookup_valid,
    input logic [1:0]        lookup_result,
    input logic              outq_full,
    input logic              lookup_accept,
    input logic              dport_stall,
    input logic              fill_valid,
    input logic              fill_accept,
    input logic              data_free,
    input logic              fill_free,
    input logic [STAT_W-1:0] avail_cycles,
    input logic [STAT_W-1:0] data_busy_cycles
);
    // R6
    accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
        lookup_accept |-> (lookup_valid && data_free && !outq_full));
    // R6
    stall_busy_chk: assert property (@(posedge clk) disable iff (rst)
        dport_stall |-> !data_free);
    // R7
    fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fill_accept |-> (fill_valid && fill_free));
    // R5
    data_idle_stays_free_chk: assert property (@(posedge clk) disable iff (rst)
        (data_free && !lookup_accept) |=> data_free);
    // R5
    fill_idle_stays_free_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_free && !fill_accept) |=> fill_free);
    // R3
    rsv_fail_free_chk: assert property (@(posedge clk) disable iff (rst)
        (lookup_accept && lookup_result == 2'd3) |=> data_free);
    // R9
    avail_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_clear && !(&avail_cycles)) |=> avail_cycles == $past(avail_cycles) + STAT_W'(1));
    // R9
    dbusy_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_clear && !data_free && !(&data_busy_cycles)) |=>
            data_busy_cycles == $past(data_busy_cycles) + STAT_W'(1));
    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat_clear |=> (avail_cycles == '0 && data_busy_cycles == '0));
    // R10
    avail_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_clear && (&avail_cycles)) |=> (&avail_cycles));
endmodule

bind cache_port_budget pbw_checker #(.STAT_W(STAT_W)) u_pbw_checker (
    .clk(clk), .rst(rst), .stat_clear(stat_clear),
    .lookup_valid(lookup_valid), .lookup_result(lookup_result),
    .outq_full(outq_full), .lookup_accept(lookup_accept),
    .dport_stall(dport_stall), .fill_valid(fill_valid),
    .fill_accept(fill_accept), .data_free(data_free), .fill_free(fill_free),
    .avail_cycles(avail_cycles), .data_busy_cycles(data_busy_cycles)
);

// File: tb/test_cache_port_budget.sv
`timescale 1ns/100ps
module test_cache_port_budget;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stat_clear = 1'b0;
    logic       lookup_valid = 1'b0;
    logic [1:0] lookup_result = 2'd0;
    logic       lookup_wb_sent = 1'b0;
    logic [7:0] lookup_bytes = 8'd0;
    logic       outq_full = 1'b0;
    logic       fill_valid = 1'b0;

    logic        lookup_accept, dport_stall, fill_accept, data_free, fill_free;
    logic [63:0] avail_cycles, data_busy_cycles, fill_busy_cycles;

    logic        s_accept, s_stall, s_faccept, s_dfree, s_ffree;
    logic [3:0]  s_avail, s_dbusy, s_fbusy;

    always #2 clk = ~clk;

    cache_port_budget i_cache_port_budget (
        .clk(clk), .rst(rst), .stat_clear(stat_clear),
        .lookup_valid(lookup_valid), .lookup_result(lookup_result),
        .lookup_wb_sent(lookup_wb_sent), .lookup_bytes(lookup_bytes),
        .outq_full(outq_full), .lookup_accept(lookup_accept),
        .dport_stall(dport_stall), .fill_valid(fill_valid),
        .fill_accept(fill_accept), .data_free(data_free), .fill_free(fill_free),
        .avail_cycles(avail_cycles), .data_busy_cycles(data_busy_cycles),
        .fill_busy_cycles(fill_busy_cycles)
    );

    cache_port_budget #(.PORT_WIDTH_CFG(0), .STAT_W(4)) i_small (
        .clk(clk), .rst(rst), .stat_clear(stat_clear),
        .lookup_valid(lookup_valid), .lookup_result(lookup_result),
        .lookup_wb_sent(lookup_wb_sent), .lookup_bytes(lookup_bytes),
        .outq_full(outq_full), .lookup_accept(s_accept),
        .dport_stall(s_stall), .fill_valid(fill_valid),
        .fill_accept(s_faccept), .data_free(s_dfree), .fill_free(s_ffree),
        .avail_cycles(s_avail), .data_busy_cycles(s_dbusy),
        .fill_busy_cycles(s_fbusy)
    );

    int checks = 0;
    int failures = 0;

    // Scoreboard queues filled by the driver, drained by the monitor
    bit          q_acc[$], q_stl[$], q_facc[$], q_df[$], q_ff[$];
    longint unsigned q_av[$], q_db[$], q_fb[$];
    string       q_tag[$];
    event        sample_ev;

    // Reference state, built from the requirements
    int unsigned     m_d = 0, m_f = 0;
    longint unsigned m_av = 0, m_db = 0, m_fb = 0;

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int unsigned cost(input logic [1:0] res, input logic wb, input logic [7:0] b);
        case (res)
            2'd0:       return (int'(b) + 31) / 32;   // R1
            2'd1, 2'd2: return wb ? 4 : 0;            // R2
            default:    return 0;                     // R3
        endcase
    endfunction

    // Called at a negedge: drive, predict, hand to monitor, advance one cycle
    task automatic step(input logic lv, input logic [1:0] res, input logic wb,
                        input logic [7:0] b, input logic oq, input logic fv,
                        input logic clr, input string tag);
        bit ea, es, efa;
        lookup_valid = lv; lookup_result = res; lookup_wb_sent = wb;
        lookup_bytes = b; outq_full = oq; fill_valid = fv; stat_clear = clr;
        #0.5;
        ea  = lv && (m_d == 0) && !oq;
        es  = lv && (m_d != 0);
        efa = fv && (m_f == 0);
        q_acc.push_back(ea); q_stl.push_back(es); q_facc.push_back(efa);
        q_df.push_back(m_d == 0); q_ff.push_back(m_f == 0);
        q_av.push_back(m_av); q_db.push_back(m_db); q_fb.push_back(m_fb);
        q_tag.push_back(tag);
        -> sample_ev;
        @(posedge clk);
        if (clr) begin
            m_av = 0; m_db = 0; m_fb = 0;
        end else begin
            m_av++;
            if (m_d != 0) m_db++;
            if (m_f != 0) m_fb++;
        end
        m_d = ((m_d != 0) ? m_d - 1 : 0) + (ea ? cost(res, wb, b) : 0);
        m_f = ((m_f != 0) ? m_f - 1 : 0) + (efa ? 4 : 0);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 2'd0, 0, 8'd0, 0, 0, 0, tag);
    endtask

    initial begin : monitor
        forever begin
            @(sample_ev);
            begin
                string t;
                t = q_tag.pop_front();
                chk({t, " accept"},    lookup_accept,    q_acc.pop_front());
                chk({t, " stall"},     dport_stall,      q_stl.pop_front());
                chk({t, " fill_acc"},  fill_accept,      q_facc.pop_front());
                chk({t, " data_free"}, data_free,        q_df.pop_front());
                chk({t, " fill_free"}, fill_free,        q_ff.pop_front());
                chk({t, " avail"},     avail_cycles,     q_av.pop_front());
                chk({t, " dbusy"},     data_busy_cycles, q_db.pop_front());
                chk({t, " fbusy"},     fill_busy_cycles, q_fb.pop_front());
            end
        end
    end

    initial begin : watchdog
        #400000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(1, "R11 reset");
        step(1, 2'd0, 0, 8'd40, 0, 0, 0, "R1 hit40");
        step(1, 2'd0, 0, 8'd8,  0, 0, 0, "R6 busy stall");
        idle(2, "R5 drain");
        step(1, 2'd0, 0, 8'd128, 0, 0, 0, "R1 hit128");
        idle(4, "R5 drain4");
        step(1, 2'd2, 0, 8'd64, 0, 0, 0, "R2 miss nowb");
        step(1, 2'd2, 1, 8'd64, 0, 0, 0, "R2 miss wb");
        idle(4, "R9 busy count");
        step(1, 2'd1, 1, 8'd16, 0, 0, 0, "R2 hrsv wb");
        idle(4, "R5 drain");
        step(1, 2'd1, 0, 8'd16, 0, 0, 0, "R2 hrsv nowb");
        step(1, 2'd3, 1, 8'd255, 0, 0, 0, "R3 rsvfail");
        step(1, 2'd0, 0, 8'd32, 1, 0, 0, "R6 outq full");
        step(0, 2'd0, 0, 8'd0, 0, 1, 0, "R4 fill");
        step(1, 2'd0, 0, 8'd33, 0, 1, 0, "R7 fill refused");
        step(0, 2'd0, 0, 8'd0, 0, 1, 0, "R7 fill retry");
        idle(3, "R4 drain");
        step(1, 2'd0, 0, 8'd1, 0, 1, 0, "R4 fill+hit");
        step(0, 2'd0, 0, 8'd0, 0, 0, 1, "R10 clear");
        idle(5, "R10 after clear");

        // R8: small instance has port width equal to the line
        step(0, 2'd0, 0, 8'd0, 0, 1, 0, "R8 fill");
        chk("R8 small fill busy", s_ffree, 0);
        idle(1, "R8 idle");
        chk("R8 small fill free after 1", s_ffree, 1);
        idle(4, "R8 idle");
        step(1, 2'd0, 0, 8'd200, 0, 0, 0, "R8 hit200");
        chk("R8 small hit busy", s_dfree, 0);
        idle(1, "R8 idle");
        chk("R8 small hit busy 2nd", s_dfree, 0);
        idle(1, "R8 idle");
        chk("R8 small hit free", s_dfree, 1);

        // R10: narrow counters saturate
        idle(20, "R10 run");
        chk("R10 small avail saturated", s_avail, 15);
        idle(1, "R10 run");
        chk("R10 small avail holds", s_avail, 15);
        chk("R10 small dbusy", s_dbusy, 2);
        chk("R10 small fbusy", s_fbusy, 1);

        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule